// File: doc/BRIEF.md
# Two-Bit Branch Target Buffer

This block predicts the next fetch address for a fetch unit. It keeps a table of recently taken branches, each with the branch address, its destination and a two-bit saturating history counter. The fetch unit sends it the current fetch address and gets back a hit flag, a taken prediction, the stored destination and the predicted next fetch address. The execute side reports every resolved branch with its address, its real outcome and its real destination, and the block trains the history counters and allocates new entries from those reports.

The table is direct-mapped with 128 slots. A branch gets a slot only the first time it is executed taken, and only when the slot it maps to currently holds the strongly not-taken state. A slot in any other state keeps its contents, so a stable, useful entry is not pushed out by a newcomer. A global enable turns the buffer off: lookups then miss and resolve reports are dropped. An invalidate-all pin returns every slot to the empty, strongly not-taken state in one cycle.

Lookups are a valid/ready request stream with a registered valid/ready response stream. A response is held stable while the consumer withholds ready, and the request side is ready only when the response register is empty or being drained in the same cycle. The resolve stream is accepted on any cycle without invalidate-all; the enable and invalidate pins are plain level controls.

Top module: `btb_top`

## Requirements
- R1: After reset every slot is empty and strongly not-taken: rsp_valid is 0, lk_ready and rs_ready are 1, and every lookup misses.
- R2: A lookup is accepted on a rising edge with lk_valid and lk_ready high; its response is presented with rsp_valid on the next cycle. lk_ready equals (not rsp_valid) or rsp_ready, and while rsp_valid is high with rsp_ready low the response fields do not change and no new request is taken.
- R3: The slot is selected by fetch address bits 8:2 and bits 31:9 are the stored tag; a lookup hits only when the slot is valid, its tag equals the address bits 31:9 and enable is high. Address bits 1:0 take no part.
- R4: History encoding is 0 strongly not-taken, 1 weakly not-taken, 2 weakly taken, 3 strongly taken. rsp_taken is 1 only on a hit in state 2 or 3, with rsp_next_pc equal to the stored destination; otherwise rsp_next_pc is the fetch address plus 4. rsp_target is the stored destination on a hit and 0 on a miss.
- R5: A resolve that hits moves the slot's history one step up on taken and one step down on not-taken, saturating at 3 and 0.
- R6: A resolve that misses and is not taken creates no entry; a resolve that misses and is taken allocates the slot.
- R7: A taken miss writes the slot (valid, new tag, destination, state 2) only when the slot is in state 0, replacing any previous branch there; in any other state the allocation is dropped and the slot is unchanged.
- R8: A taken hit rewrites the stored destination with the reported one; a not-taken hit leaves it unchanged.
- R9: While enable is low, lookups miss and resolve reports change nothing.
- R10: While inv_all is high rs_ready is 0; at that edge every slot becomes empty and strongly not-taken.
- R11: A lookup and a resolve accepted on the same edge for the same slot: the lookup sees the slot as it was before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Buffer enable |
| inv_all | input | 1 | Clear every slot this cycle |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_pc | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Lookup response ready |
| rsp_hit | output | 1 | Slot matched the address |
| rsp_taken | output | 1 | Predicted taken |
| rsp_target | output | 32 | Stored destination on a hit, else 0 |
| rsp_next_pc | output | 32 | Predicted next fetch address |
| rs_valid | input | 1 | Resolve report valid |
| rs_ready | output | 1 | Resolve report ready |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | Real outcome, 1 for taken |
| rs_target | input | 32 | Real destination |

## Verification
A lookup response is due on the cycle after its accepting edge, and a resolve changes the table at its own accepting edge, so the first lookup that can observe it is one accepted on a later edge. The bench drives every input one nanosecond after a rising edge and compares outputs on the falling edge, where the response from the previous edge is settled; each lookup pushes its expected result, computed from a model of the table at issue time, into a queue that the monitor pops as responses arrive. The same-edge case and the stalled-response case are arranged so that the expected value is fixed at the moment of acceptance, not when the consumer finally takes it.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Two-bit saturating history; bit 1 set means "predict taken".
  typedef enum logic [1:0] {
    HIST_SNT = 2'b00,
    HIST_WNT = 2'b01,
    HIST_WT  = 2'b10,
    HIST_ST  = 2'b11
  } hist_e;

  function automatic logic hist_taken(hist_e h);
    return h[1];
  endfunction

endpackage

// File: rtl/btb_hist_next.sv
module btb_hist_next
  import btb_pkg::*;
(
  input  hist_e cur,
  input  logic  taken,
  output hist_e nxt
);

  always_comb begin
    nxt = cur;
    unique case (cur)
      HIST_SNT: nxt = taken ? HIST_WNT : HIST_SNT;
      HIST_WNT: nxt = taken ? HIST_WT  : HIST_SNT;
      HIST_WT:  nxt = taken ? HIST_ST  : HIST_WNT;
      HIST_ST:  nxt = taken ? HIST_ST  : HIST_WT;
      default:  nxt = HIST_SNT;
    endcase
  end

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 7,
  parameter int TAG_W  = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  // read port A: lookup side
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [ADDR_W-1:0] ra_tgt,
  output hist_e             ra_hist,
  // read port B: resolve side
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag,
  output hist_e             rb_hist,
  // single write index shared by all write enables
  input  logic [IDX_W-1:0]  w_idx,
  input  logic              hist_we,
  input  hist_e             hist_wval,
  input  logic              alloc_we,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              tgt_we,
  input  logic [ADDR_W-1:0] tgt_wval
);

  localparam int ENTRIES = 1 << IDX_W;

  logic              valid_q [ENTRIES];
  hist_e             hist_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q   [ENTRIES];
  logic [ADDR_W-1:0] tgt_q   [ENTRIES];

  // State that must be known after reset / clear lives in resettable flops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= 1'b0;
        hist_q[i]  <= HIST_SNT;
      end
    end else if (clr_all) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= 1'b0;
        hist_q[i]  <= HIST_SNT;
      end
    end else begin
      if (hist_we)  hist_q[w_idx]  <= hist_wval;
      if (alloc_we) valid_q[w_idx] <= 1'b1;
    end
  end

  // Payload is only meaningful behind a valid bit: no reset needed.
  always_ff @(posedge clk) begin
    if (alloc_we) tag_q[w_idx] <= alloc_tag;
    if (tgt_we)   tgt_q[w_idx] <= tgt_wval;
  end

  assign ra_valid = valid_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_tgt   = tgt_q[ra_idx];
  assign ra_hist  = hist_q[ra_idx];

  assign rb_valid = valid_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_hist  = hist_q[rb_idx];

endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 7,
  parameter int IDX_LSB = 2,
  parameter int TAG_W   = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [ADDR_W-1:0] rd_tgt,
  input  hist_e             rd_hist,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_target,
  output logic [ADDR_W-1:0] rsp_next_pc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << IDX_LSB);

  logic accept;
  logic hit_c;
  logic taken_c;

  assign lk_ready = !rsp_valid || rsp_ready;
  assign accept   = lk_valid && lk_ready;
  assign rd_idx   = lk_pc[IDX_LSB +: IDX_W];
  assign hit_c    = en && rd_valid && (rd_tag == lk_pc[ADDR_W-1 -: TAG_W]);
  assign taken_c  = hit_c && hist_taken(rd_hist);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_taken   <= 1'b0;
      rsp_target  <= '0;
      rsp_next_pc <= '0;
    end else if (accept) begin
      rsp_valid   <= 1'b1;
      rsp_hit     <= hit_c;
      rsp_taken   <= taken_c;
      rsp_target  <= hit_c ? rd_tgt : '0;
      rsp_next_pc <= taken_c ? rd_tgt : (lk_pc + STEP);
    end else if (rsp_ready) begin
      rsp_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/btb_update.sv
module btb_update
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 7,
  parameter int IDX_LSB = 2,
  parameter int TAG_W   = 23
) (
  input  logic              fire,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic              rd_valid,
  input  logic [TAG_W-1:0]  rd_tag,
  input  hist_e             rd_hist,
  output logic [IDX_W-1:0]  w_idx,
  output logic              hist_we,
  output hist_e             hist_wval,
  output logic              alloc_we,
  output logic [TAG_W-1:0]  alloc_tag,
  output logic              tgt_we,
  output logic [ADDR_W-1:0] tgt_wval
);

  logic             hit;
  logic [TAG_W-1:0] tag;
  hist_e            trained;
  logic             unused_lsb;

  assign rd_idx     = rs_pc[IDX_LSB +: IDX_W];
  assign w_idx      = rd_idx;
  assign tag        = rs_pc[ADDR_W-1 -: TAG_W];
  assign hit        = rd_valid && (rd_tag == tag);
  assign alloc_tag  = tag;
  assign tgt_wval   = rs_target;
  assign unused_lsb = ^rs_pc[IDX_LSB-1:0];

  btb_hist_next u_next (
    .cur   (rd_hist),
    .taken (rs_taken),
    .nxt   (trained)
  );

  always_comb begin
    hist_we   = 1'b0;
    hist_wval = trained;
    alloc_we  = 1'b0;
    tgt_we    = 1'b0;
    if (fire) begin
      if (hit) begin
        hist_we = 1'b1;
        tgt_we  = rs_taken;
      end else if (rs_taken && (rd_hist == HIST_SNT)) begin
        // first taken execution, slot is free to be claimed
        hist_we   = 1'b1;
        hist_wval = HIST_WT;
        alloc_we  = 1'b1;
        tgt_we    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/btb_top.sv
module btb_top
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 7,
  parameter int IDX_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              inv_all,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_target,
  output logic [ADDR_W-1:0] rsp_next_pc,
  input  logic              rs_valid,
  output logic              rs_ready,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  input  logic [ADDR_W-1:0] rs_target
);

  localparam int TAG_W = ADDR_W - IDX_W - IDX_LSB;

  logic [IDX_W-1:0]  ra_idx, rb_idx, w_idx;
  logic              ra_valid, rb_valid;
  logic [TAG_W-1:0]  ra_tag, rb_tag, alloc_tag;
  logic [ADDR_W-1:0] ra_tgt, tgt_wval;
  hist_e             ra_hist, rb_hist, hist_wval;
  logic              hist_we, alloc_we, tgt_we;
  logic              rs_fire;

  assign rs_ready = !inv_all;
  assign rs_fire  = rs_valid && rs_ready && en;

  btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_all   (inv_all),
    .ra_idx    (ra_idx),
    .ra_valid  (ra_valid),
    .ra_tag    (ra_tag),
    .ra_tgt    (ra_tgt),
    .ra_hist   (ra_hist),
    .rb_idx    (rb_idx),
    .rb_valid  (rb_valid),
    .rb_tag    (rb_tag),
    .rb_hist   (rb_hist),
    .w_idx     (w_idx),
    .hist_we   (hist_we),
    .hist_wval (hist_wval),
    .alloc_we  (alloc_we),
    .alloc_tag (alloc_tag),
    .tgt_we    (tgt_we),
    .tgt_wval  (tgt_wval)
  );

  btb_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .TAG_W(TAG_W)) u_lookup (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .lk_valid    (lk_valid),
    .lk_ready    (lk_ready),
    .lk_pc       (lk_pc),
    .rd_idx      (ra_idx),
    .rd_valid    (ra_valid),
    .rd_tag      (ra_tag),
    .rd_tgt      (ra_tgt),
    .rd_hist     (ra_hist),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_hit     (rsp_hit),
    .rsp_taken   (rsp_taken),
    .rsp_target  (rsp_target),
    .rsp_next_pc (rsp_next_pc)
  );

  btb_update #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .TAG_W(TAG_W)) u_update (
    .fire      (rs_fire),
    .rs_pc     (rs_pc),
    .rs_taken  (rs_taken),
    .rs_target (rs_target),
    .rd_idx    (rb_idx),
    .rd_valid  (rb_valid),
    .rd_tag    (rb_tag),
    .rd_hist   (rb_hist),
    .w_idx     (w_idx),
    .hist_we   (hist_we),
    .hist_wval (hist_wval),
    .alloc_we  (alloc_we),
    .alloc_tag (alloc_tag),
    .tgt_we    (tgt_we),
    .tgt_wval  (tgt_wval)
  );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              inv_all,
  input logic              lk_valid,
  input logic              lk_ready,
  input logic [ADDR_W-1:0] lk_pc,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_hit,
  input logic              rsp_taken,
  input logic [ADDR_W-1:0] rsp_target,
  input logic [ADDR_W-1:0] rsp_next_pc,
  input logic              rs_ready
);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pc_q <= '0;
    else if (lk_valid && lk_ready) pc_q <= lk_pc;
  end

  // R2: an accepted request produces a response on the next cycle
  assert_accept_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> rsp_valid);

  // R2: a stalled response stays put
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_taken)
                                   && $stable(rsp_target) && $stable(rsp_next_pc)));

  // R4: a taken prediction implies a hit and redirects to the stored destination
  assert_taken_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_taken) |-> (rsp_hit && rsp_next_pc == rsp_target));

  // R4: otherwise the sequential address of the accepted request
  assert_fallthrough_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_taken) |-> (rsp_next_pc == pc_q + ADDR_W'(4)));

  // R4: a miss reports a zero destination
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_target == '0));

  // R9: a lookup taken while disabled never hits
  assert_disabled_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !en) |=> !rsp_hit);

  // R10: clearing blocks resolve reports
  assert_clear_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |-> !rs_ready);

endmodule

bind btb_top btb_checker #(.ADDR_W(ADDR_W)) u_btb_checker (.*);

// File: tb/tb_btb_top.sv
module tb_btb_top;

  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b1;
  logic          inv_all = 1'b0;
  logic          lk_valid = 1'b0;
  logic          lk_ready;
  logic [AW-1:0] lk_pc = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic          rsp_hit;
  logic          rsp_taken;
  logic [AW-1:0] rsp_target;
  logic [AW-1:0] rsp_next_pc;
  logic          rs_valid = 1'b0;
  logic          rs_ready;
  logic [AW-1:0] rs_pc = '0;
  logic          rs_taken = 1'b0;
  logic [AW-1:0] rs_target = '0;

  always #4 clk = ~clk;

  btb_top dut (
    .clk(clk), .rst_n(rst_n), .en(en), .inv_all(inv_all),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_pc(lk_pc),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_taken(rsp_taken), .rsp_target(rsp_target), .rsp_next_pc(rsp_next_pc),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_pc(rs_pc),
    .rs_taken(rs_taken), .rs_target(rs_target)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  typedef struct {
    string         req;
    bit            hit;
    bit            taken;
    logic [AW-1:0] tgt;
    logic [AW-1:0] nxt;
  } exp_t;

  exp_t expq[$];

  // table model built from the requirements
  bit            m_valid [128];
  logic [22:0]   m_tag   [128];
  logic [AW-1:0] m_tgt   [128];
  int            m_hist  [128];

  function automatic int idx_of(logic [AW-1:0] pc);
    return int'(pc[8:2]);
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 128; i++) begin
      m_valid[i] = 1'b0;
      m_hist[i]  = 0;
      m_tgt[i]   = '0;
      m_tag[i]   = '0;
    end
  endfunction

  function automatic exp_t predict(string req, logic [AW-1:0] pc);
    exp_t e;
    int   i = idx_of(pc);
    e.req   = req;
    e.hit   = en && m_valid[i] && (m_tag[i] == pc[31:9]);
    e.taken = e.hit && (m_hist[i] >= 2);
    e.tgt   = e.hit ? m_tgt[i] : '0;
    e.nxt   = e.taken ? m_tgt[i] : pc + 32'd4;
    return e;
  endfunction

  function automatic void model_resolve(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tgt);
    int i = idx_of(pc);
    if (m_valid[i] && m_tag[i] == pc[31:9]) begin
      m_hist[i] = tk ? ((m_hist[i] < 3) ? m_hist[i] + 1 : 3)
                     : ((m_hist[i] > 0) ? m_hist[i] - 1 : 0);
      if (tk) m_tgt[i] = tgt;
    end else if (tk && m_hist[i] == 0) begin
      m_valid[i] = 1'b1;
      m_tag[i]   = pc[31:9];
      m_tgt[i]   = tgt;
      m_hist[i]  = 2;
    end
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic lookup(string req, logic [AW-1:0] pc);
    step();
    lk_valid = 1'b1;
    lk_pc    = pc;
    expq.push_back(predict(req, pc));
    step();
    lk_valid = 1'b0;
  endtask

  task automatic resolve(logic [AW-1:0] pc, bit tk, logic [AW-1:0] tgt);
    step();
    rs_valid  = 1'b1;
    rs_pc     = pc;
    rs_taken  = tk;
    rs_target = tgt;
    step();
    rs_valid = 1'b0;
    if (en) model_resolve(pc, tk, tgt);
  endtask

  // monitor: compares each delivered response with the oldest expectation
  always @(negedge clk) begin : monitor
    exp_t e;
    if (rst_n && rsp_valid && rsp_ready) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R2 unexpected response actual=1 expected=0");
      end else begin
        e = expq.pop_front();
        if (rsp_hit !== e.hit || rsp_taken !== e.taken ||
            rsp_target !== e.tgt || rsp_next_pc !== e.nxt) begin
          bad++;
          $display("FAIL %s actual hit=%0b taken=%0b tgt=%h nxt=%h expected hit=%0b taken=%0b tgt=%h nxt=%h",
                   e.req, rsp_hit, rsp_taken, rsp_target, rsp_next_pc,
                   e.hit, e.taken, e.tgt, e.nxt);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] pa, pb, pc3, s_nxt, s_tgt;
    logic          s_tk;
    pa  = 32'h0000_1040;
    pb  = pa + 32'h200;
    pc3 = 32'h0000_01FC;
    model_clear();
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 lk_ready",  {31'b0, lk_ready},  32'd1);
    check("R1 rs_ready",  {31'b0, rs_ready},  32'd1);
    lookup("R1", pa);
    lookup("R1", 32'h0000_0000);
    lookup("R1", 32'hFFFF_FFFC);

    // R6: not-taken miss leaves nothing, taken miss allocates
    resolve(pa, 1'b0, 32'h0000_2000);
    lookup("R6", pa);
    resolve(pa, 1'b1, 32'h0000_2000);
    lookup("R6", pa);

    // R5: walk the counter both ways, including both saturation ends
    resolve(pa, 1'b0, 32'h0); lookup("R5", pa);
    resolve(pa, 1'b0, 32'h0); lookup("R5", pa);
    resolve(pa, 1'b0, 32'h0); lookup("R5", pa);
    resolve(pa, 1'b1, 32'h0000_2000); lookup("R5", pa);
    resolve(pa, 1'b1, 32'h0000_2000); lookup("R5", pa);
    resolve(pa, 1'b1, 32'h0000_2000); lookup("R5", pa);
    resolve(pa, 1'b1, 32'h0000_2000); lookup("R5", pa);
    resolve(pa, 1'b0, 32'h0); lookup("R5", pa);

    // R3: index/tag split and ignored low bits
    lookup("R3", pb);
    lookup("R3", pa + 32'd4);
    lookup("R3", pa + 32'd2);

    // R7: busy slot refuses, free slot is replaced
    resolve(pb, 1'b1, 32'h0000_3000);
    lookup("R7", pb);
    lookup("R7", pa);
    resolve(pa, 1'b0, 32'h0);
    resolve(pa, 1'b0, 32'h0);
    resolve(pb, 1'b1, 32'h0000_3000);
    lookup("R7", pb);
    lookup("R7", pa);

    // R8: destination refresh only on taken hits
    resolve(pb, 1'b1, 32'h4444_0000);
    lookup("R8", pb);
    resolve(pb, 1'b0, 32'h5555_0000);
    lookup("R8", pb);

    // R4: hit with a not-taken state predicts fall-through
    resolve(pb, 1'b0, 32'h0);
    lookup("R4", pb);

    // R9: disabled buffer misses and ignores reports
    step(); en = 1'b0;
    lookup("R9", pb);
    resolve(pb, 1'b1, 32'h7777_0000);
    resolve(pb, 1'b1, 32'h7777_0000);
    step(); en = 1'b1;
    lookup("R9", pb);

    // R6: many slots, one index collides with the busy slot of pb
    for (int k = 0; k < 16; k++)
      resolve(32'h8000_0000 | (AW'(k * 8) << 2), 1'b1, 32'h9000_0000 + AW'(k * 16));
    for (int k = 0; k < 16; k++)
      lookup("R6", 32'h8000_0000 | (AW'(k * 8) << 2));

    // R11: lookup and resolve on the same edge for the same slot
    step();
    lk_valid = 1'b1; lk_pc = pc3;
    expq.push_back(predict("R11", pc3));
    rs_valid = 1'b1; rs_pc = pc3; rs_taken = 1'b1; rs_target = 32'h0000_6000;
    step();
    lk_valid = 1'b0; rs_valid = 1'b0;
    model_resolve(pc3, 1'b1, 32'h0000_6000);
    lookup("R11", pc3);

    // R2: stalled response holds, new requests wait
    step();
    rsp_ready = 1'b0;
    lk_valid = 1'b1; lk_pc = pc3;
    expq.push_back(predict("R2", pc3));
    step();
    lk_valid = 1'b0;
    check("R2 lk_ready stalled", {31'b0, lk_ready}, 32'd0);
    s_tk = rsp_taken; s_nxt = rsp_next_pc; s_tgt = rsp_target;
    resolve(pc3, 1'b0, 32'h0);
    lk_valid = 1'b1; lk_pc = pa;
    step();
    step();
    lk_valid = 1'b0;
    check("R2 hold taken",  {31'b0, rsp_taken}, {31'b0, s_tk});
    check("R2 hold next",   rsp_next_pc, s_nxt);
    check("R2 hold target", rsp_target, s_tgt);
    check("R2 hold valid",  {31'b0, rsp_valid}, 32'd1);
    rsp_ready = 1'b1;
    step();
    step();
    lookup("R2", pc3);

    // R10: clear blocks a concurrent report and empties the table
    step();
    inv_all = 1'b1;
    rs_valid = 1'b1; rs_pc = 32'h0000_0100; rs_taken = 1'b1; rs_target = 32'h0000_0F00;
    #1 check("R10 rs_ready", {31'b0, rs_ready}, 32'd0);
    step();
    inv_all = 1'b0; rs_valid = 1'b0;
    model_clear();
    lookup("R10", pa);
    lookup("R10", pb);
    lookup("R10", pc3);
    lookup("R10", 32'h0000_0100);
    lookup("R10", 32'h8000_0000);
    resolve(pc3, 1'b1, 32'h0000_6000);
    lookup("R10", pc3);

    for (int w = 0; w < 20 && expq.size() != 0; w++) step();
    repeat (3) step();
    if (expq.size() != 0) begin
      total++;
      bad++;
      $display("FAIL R2 missing responses actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule